// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block keeps the speculative state of a small direct-mapped data cache while the core runs a hardware memory transaction. Each line holds one data word plus valid and dirty bits. Inside a transaction the block also keeps a read-membership bit and a write-membership bit for each line. It watches snooped traffic from other agents for accesses that collide with the lines the transaction has touched. After a collision, the core's later accesses become flagged no-ops, and each of their responses carries a failure reason. The core then ends the transaction. On commit, the speculative writes become visible. On abort, they are discarded.

Transaction control travels on the core request port as a kind of load. With `req_store` low, `req_cmd` selects the operation: 00 is a plain load, 01 is begin, 10 is commit and 11 is abort. With `req_store` high, the request is a store and `req_cmd` is ignored. A load miss fills the line with the word presented on `req_wdata`. The block answers every request exactly one cycle after it is accepted.

Top module: `htm_line_tracker`

## Requirements
- R1: After reset no transaction is active, every line is invalid and clean, and no response is pending.
- R2: Outside a transaction, a load to a valid line responds with hit=1 and the stored word. A load to an invalid line responds with hit=0 and the fill word, and that line then becomes valid. A store writes its word and leaves the line valid and dirty. Every response appears one cycle after its request, and a cycle without a request gives no response.
- R3: Begin (cmd 01) enters the transactional mode. Begin inside a transaction has no effect. Commit or abort outside a transaction changes nothing and responds without the failed flag.
- R4: Inside a transaction, a remote invalidation of a line that the transaction has read or written fails the transaction with reason 2'b01. An invalidation of any other line only invalidates that line.
- R5: Inside a transaction, a remote read of a speculatively written line fails the transaction with reason 2'b10. A remote read of any line that is not speculatively written causes no failure and clears that line's dirty bit.
- R6: While the transaction is failed, loads and stores leave the cache unchanged. Their responses carry failed=1, hit=0 and data 0.
- R7: The first failure reason is held until the transaction ends. When both snoop kinds conflict in the same cycle, the reason is 2'b01.
- R8: Abort (cmd 11) invalidates and cleans every speculatively written line, keeps lines that were only read, clears the failure and leaves the transactional mode. Its response carries the failed flag and reason if the transaction had failed.
- R9: Commit (cmd 10) of a transaction that has not failed leaves every speculatively written line valid and dirty, leaves the transactional mode, and responds with failed=0.
- R10: Commit of a failed transaction acts as an abort, and its response carries failed=1 with the held reason.
- R11: A snoop in the same cycle as a core access is applied first. The access sees the failure or the invalidation that the snoop causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_store | input | 1 | 1 = store, 0 = load-class request |
| req_cmd | input | 2 | Load subtype: 00 load, 01 begin, 10 commit, 11 abort |
| req_idx | input | IDX_W | Line index of the access |
| req_wdata | input | DATA_W | Store word, or fill word on a load miss |
| snp_inv_valid | input | 1 | Remote invalidation present |
| snp_inv_idx | input | IDX_W | Line index of the invalidation |
| snp_rd_valid | input | 1 | Remote read present |
| snp_rd_idx | input | IDX_W | Line index of the remote read |
| rsp_valid | output | 1 | Response to the request from the previous cycle |
| rsp_hit | output | 1 | Access found the line valid |
| rsp_rdata | output | DATA_W | Load data (0 for stores, commands and flagged accesses) |
| rsp_failed | output | 1 | Transaction-failed flag |
| rsp_reason | output | 2 | Failure reason: 01 invalidation, 10 remote read, 00 none |
| tx_active | output | 1 | Transactional mode is on |
| line_valid | output | LINES | Valid bit of each line |
| line_dirty | output | LINES | Dirty bit of each line |

## Verification
The assertions take for granted that the core does not send a second begin as a way to recover. They also take for granted that snoop indices are meaningful only while their valid bits are high, and that a commit or abort is the only way a failed transaction ends. The stimulus keeps one request per cycle and drives the snoop indices only with their valid bits. It always closes a failed transaction with a commit or an abort before it begins the next one. Snoops are placed in the same cycle as core accesses to lines the transaction has read, to lines it has written and to lines it has not touched, so that the snoop-first ordering is visible in the responses.

// File: rtl/htm_line_tracker.sv
module htm_line_tracker #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_cmd,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snp_inv_valid,
  input  logic [IDX_W-1:0]  snp_inv_idx,
  input  logic              snp_rd_valid,
  input  logic [IDX_W-1:0]  snp_rd_idx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_failed,
  output logic [1:0]        rsp_reason,
  output logic              tx_active,
  output logic [LINES-1:0]  line_valid,
  output logic [LINES-1:0]  line_dirty
);

  localparam logic [1:0] CMD_LOAD = 2'b00, CMD_BEGIN = 2'b01, CMD_COMMIT = 2'b10, CMD_ABORT = 2'b11;
  localparam logic [1:0] WHY_INV = 2'b01, WHY_RD = 2'b10;

  logic [DATA_W-1:0] word_q [LINES];
  logic [LINES-1:0]  vld_q, drt_q, rset_q, wset_q;
  logic [LINES-1:0]  vld_n, drt_n, rset_n, wset_n;
  logic              tx_q, tx_n, fail_q, fail_n;
  logic [1:0]        why_q, why_n;
  logic              word_we, hit_now;

  wire is_ld  = req_valid && !req_store && req_cmd == CMD_LOAD;
  wire is_st  = req_valid && req_store;
  wire is_beg = req_valid && !req_store && req_cmd == CMD_BEGIN;
  wire is_cmt = req_valid && !req_store && req_cmd == CMD_COMMIT;
  wire is_abt = req_valid && !req_store && req_cmd == CMD_ABORT;

  wire inv_conf = snp_inv_valid && tx_q && (rset_q[snp_inv_idx] || wset_q[snp_inv_idx]);
  wire rd_conf  = snp_rd_valid && tx_q && wset_q[snp_rd_idx];
  wire fail_now = fail_q || inv_conf || rd_conf;
  wire [1:0] why_now = fail_q ? why_q : inv_conf ? WHY_INV : rd_conf ? WHY_RD : 2'b00;
  wire blocked  = tx_q && fail_now;
  wire discard  = tx_q && (is_abt || (is_cmt && fail_now));
  wire publish  = tx_q && is_cmt && !fail_now;

  always_comb begin
    vld_n   = vld_q;
    drt_n   = drt_q;
    rset_n  = rset_q;
    wset_n  = wset_q;
    tx_n    = tx_q;
    fail_n  = fail_now;
    why_n   = why_now;
    word_we = 1'b0;
    if (snp_inv_valid) begin
      vld_n[snp_inv_idx] = 1'b0;
      drt_n[snp_inv_idx] = 1'b0;
    end
    if (snp_rd_valid && !(tx_q && wset_q[snp_rd_idx]))
      drt_n[snp_rd_idx] = 1'b0;
    hit_now = vld_n[req_idx];
    if (is_ld && !blocked) begin
      if (!hit_now) begin
        vld_n[req_idx] = 1'b1;
        word_we = 1'b1;
      end
      if (tx_q) rset_n[req_idx] = 1'b1;
    end
    if (is_st && !blocked) begin
      vld_n[req_idx] = 1'b1;
      word_we = 1'b1;
      if (tx_q) wset_n[req_idx] = 1'b1;
      else      drt_n[req_idx] = 1'b1;
    end
    if (is_beg && !tx_q) tx_n = 1'b1;
    if (discard) begin
      vld_n  = vld_n & ~wset_q;
      drt_n  = drt_n & ~wset_q;
      rset_n = '0;
      wset_n = '0;
      fail_n = 1'b0;
      why_n  = 2'b00;
      tx_n   = 1'b0;
    end else if (publish) begin
      vld_n  = vld_n | wset_q;
      drt_n  = drt_n | wset_q;
      rset_n = '0;
      wset_n = '0;
      tx_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0; drt_q <= '0; rset_q <= '0; wset_q <= '0;
      tx_q <= 1'b0; fail_q <= 1'b0; why_q <= 2'b00;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_rdata <= '0;
      rsp_failed <= 1'b0; rsp_reason <= 2'b00;
    end else begin
      vld_q <= vld_n; drt_q <= drt_n; rset_q <= rset_n; wset_q <= wset_n;
      tx_q <= tx_n; fail_q <= fail_n; why_q <= why_n;
      rsp_valid  <= req_valid;
      rsp_failed <= req_valid && blocked;
      rsp_reason <= (req_valid && blocked) ? why_now : 2'b00;
      rsp_hit    <= (is_ld || is_st) && !blocked && hit_now;
      rsp_rdata  <= (is_ld && !blocked) ? (hit_now ? word_q[req_idx] : req_wdata) : '0;
    end
  end

  always_ff @(posedge clk)
    if (word_we) word_q[req_idx] <= req_wdata;

  assign tx_active  = tx_q;
  assign line_valid = vld_q;
  assign line_dirty = drt_q;

  p_fail_inside_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> tx_q);
  p_sets_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_q |-> (rset_q == '0 && wset_q == '0));
  p_reason_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !discard) |=> (fail_q && why_q == $past(why_q)));
  p_flagged_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_failed) |-> (!rsp_hit && rsp_rdata == '0 && rsp_reason != 2'b00));
  p_abort_discards_r8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (!tx_q && !fail_q && (vld_q & $past(wset_q)) == '0));
  p_commit_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> (!tx_q && (drt_q & $past(wset_q)) == $past(wset_q)));
  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

endmodule

// File: tb/htm_line_tracker_bench.sv
module htm_line_tracker_bench;
  localparam int LINES = 16, DATA_W = 32, IDX_W = 4;

  typedef struct packed {
    logic rq; logic st; logic [1:0] cmd; logic [3:0] idx; logic [31:0] wd;
    logic iv; logic [3:0] ii; logic rv; logic [3:0] ri;
    logic e_hit; logic e_fail; logic [1:0] e_why; logic [31:0] e_rd; logic e_tx; logic [3:0] tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1,0,2'b00,4'd3,32'hA,0,4'd0,0,4'd0, 0,0,2'b00,32'hA,0,4'd2},   // R2 miss fill
    '{1,0,2'b00,4'd3,32'h9,0,4'd0,0,4'd0, 1,0,2'b00,32'hA,0,4'd2},   // R2 hit
    '{1,1,2'b00,4'd5,32'hB,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,0,4'd2},   // R2 store
    '{1,0,2'b00,4'd5,32'h0,0,4'd0,0,4'd0, 1,0,2'b00,32'hB,0,4'd2},
    '{1,0,2'b01,4'd0,32'h0,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,1,4'd3},   // R3 begin
    '{1,0,2'b00,4'd3,32'h0,0,4'd0,0,4'd0, 1,0,2'b00,32'hA,1,4'd2},
    '{1,1,2'b00,4'd7,32'hC,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,1,4'd2},
    '{1,0,2'b00,4'd7,32'h0,0,4'd0,0,4'd0, 1,0,2'b00,32'hC,1,4'd2},
    '{1,0,2'b00,4'd5,32'h0,0,4'd0,1,4'd3, 1,0,2'b00,32'hB,1,4'd5},   // R5 read of read-only line
    '{1,0,2'b00,4'd5,32'h0,0,4'd0,1,4'd7, 0,1,2'b10,32'h0,1,4'd11},  // R11 R5 same-cycle fail
    '{1,1,2'b00,4'd5,32'hD,1,4'd3,0,4'd0, 0,1,2'b10,32'h0,1,4'd7},   // R7 R6 reason held
    '{1,0,2'b10,4'd0,32'h0,0,4'd0,0,4'd0, 0,1,2'b10,32'h0,0,4'd10},  // R10 commit as abort
    '{1,0,2'b00,4'd7,32'hE,0,4'd0,0,4'd0, 0,0,2'b00,32'hE,0,4'd10},  // line 7 discarded
    '{1,0,2'b00,4'd5,32'h0,0,4'd0,0,4'd0, 1,0,2'b00,32'hB,0,4'd6},   // R6 store was no-op
    '{1,0,2'b00,4'd3,32'hF,0,4'd0,0,4'd0, 0,0,2'b00,32'hF,0,4'd4},   // R4 line invalidated
    '{1,0,2'b01,4'd0,32'h0,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,1,4'd3},
    '{1,1,2'b00,4'd9,32'h6,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,1,4'd9},
    '{1,0,2'b00,4'd3,32'h8,1,4'd3,0,4'd0, 0,0,2'b00,32'h8,1,4'd4},   // R4 R11 non-member inval first
    '{1,0,2'b10,4'd0,32'h0,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,0,4'd9},   // R9 commit
    '{1,0,2'b00,4'd9,32'h0,0,4'd0,0,4'd0, 1,0,2'b00,32'h6,0,4'd9},
    '{1,0,2'b01,4'd0,32'h0,0,4'd0,0,4'd0, 0,0,2'b00,32'h0,1,4'd3},
    '{1,0,2'b00,4'd2,32'h7,0,4'd0,0,4'd0, 0,0,2'b00,32'h7,1,4'd2},
    '{1,0,2'b00,4'd4,32'h5,1,4'd2,0,4'd0, 0,1,2'b01,32'h0,1,4'd4},   // R4 inval of read line
    '{1,0,2'b11,4'd0,32'h0,0,4'd0,0,4'd0, 0,1,2'b01,32'h0,0,4'd8},   // R8 abort
    '{1,0,2'b00,4'd4,32'h4,0,4'd0,0,4'd0, 0,0,2'b00,32'h4,0,4'd8}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, snp_inv_valid = 0, snp_rd_valid = 0;
  logic [1:0] req_cmd = 0;
  logic [IDX_W-1:0] req_idx = 0, snp_inv_idx = 0, snp_rd_idx = 0;
  logic [DATA_W-1:0] req_wdata = 0;
  logic rsp_valid, rsp_hit, rsp_failed, tx_active;
  logic [DATA_W-1:0] rsp_rdata;
  logic [1:0] rsp_reason;
  logic [LINES-1:0] line_valid, line_dirty;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  htm_line_tracker #(.LINES(LINES), .DATA_W(DATA_W)) u_htm_line_tracker (.*);

  task automatic chk(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic rq, input logic st, input logic [1:0] cmd, input logic [3:0] idx,
                       input logic [31:0] wd, input logic iv, input logic [3:0] ii,
                       input logic rv, input logic [3:0] ri);
    req_valid = rq; req_store = st; req_cmd = cmd; req_idx = idx; req_wdata = wd;
    snp_inv_valid = iv; snp_inv_idx = ii; snp_rd_valid = rv; snp_rd_idx = ri;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_store = 0; req_cmd = 0; snp_inv_valid = 0; snp_rd_valid = 0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "tx_active", tx_active, 0);
    chk(1, "line_valid", line_valid, 0);
    chk(1, "line_dirty", line_dirty, 0);
    chk(1, "rsp_valid", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].rq, VEC[i].st, VEC[i].cmd, VEC[i].idx, VEC[i].wd,
            VEC[i].iv, VEC[i].ii, VEC[i].rv, VEC[i].ri);
      chk(VEC[i].tag, $sformatf("v%0d rsp_valid", i), rsp_valid, 1);
      chk(VEC[i].tag, $sformatf("v%0d rsp_hit", i), rsp_hit, VEC[i].e_hit);
      chk(VEC[i].tag, $sformatf("v%0d rsp_failed", i), rsp_failed, VEC[i].e_fail);
      chk(VEC[i].tag, $sformatf("v%0d rsp_reason", i), rsp_reason, VEC[i].e_why);
      chk(VEC[i].tag, $sformatf("v%0d rsp_rdata", i), rsp_rdata, VEC[i].e_rd);
      chk(VEC[i].tag, $sformatf("v%0d tx_active", i), tx_active, VEC[i].e_tx);
    end
    // R9 committed line 9 dirty, R2 line 5 dirty; R8 line 7 refilled clean
    chk(9, "line_dirty after table", line_dirty, 16'h0220);
    chk(8, "line_valid after table", line_valid, 16'h02B8);

    // R5 remote read outside a transaction cleans the line; R2 no request gives no response
    apply(0, 0, 2'b00, 4'd0, 0, 0, 4'd0, 1, 4'd5);
    chk(5, "dirty after remote read", line_dirty, 16'h0200);
    chk(2, "rsp_valid idle", rsp_valid, 0);

    // R8 abort discards written line, keeps read line
    apply(1, 0, 2'b01, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    apply(1, 0, 2'b00, 4'd5, 0, 0, 4'd0, 0, 4'd0);
    apply(1, 1, 2'b00, 4'd9, 32'h77, 0, 4'd0, 0, 4'd0);
    apply(1, 0, 2'b11, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    chk(8, "abort rsp_failed", rsp_failed, 0);
    chk(8, "valid after abort", line_valid, 16'h00B8);
    chk(8, "dirty after abort", line_dirty, 16'h0000);
    chk(8, "tx after abort", tx_active, 0);

    // R3 nested begin ignored; commit outside transaction is harmless
    apply(1, 0, 2'b01, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    apply(1, 0, 2'b01, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    chk(3, "tx after second begin", tx_active, 1);
    apply(1, 0, 2'b10, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    chk(3, "tx after single commit", tx_active, 0);
    apply(1, 0, 2'b10, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    chk(3, "idle commit rsp_failed", rsp_failed, 0);
    chk(3, "idle commit tx", tx_active, 0);
    chk(3, "idle commit valid", line_valid, 16'h00B8);

    // R7 both snoops conflict together: reason is invalidation
    apply(1, 0, 2'b01, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    apply(1, 1, 2'b00, 4'd1, 32'h11, 0, 4'd0, 0, 4'd0);
    apply(0, 0, 2'b00, 4'd0, 0, 1, 4'd1, 1, 4'd1);
    apply(1, 0, 2'b00, 4'd1, 0, 0, 4'd0, 0, 4'd0);
    chk(7, "dual conflict failed", rsp_failed, 1);
    chk(7, "dual conflict reason", rsp_reason, 2'b01);
    apply(1, 0, 2'b11, 4'd0, 0, 0, 4'd0, 0, 4'd0);
    chk(8, "line 1 after abort", line_valid[1], 0);
    chk(8, "tx after final abort", tx_active, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule